// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block decides when an analog-to-digital converter samples and converts, and for how long. Software writes a 16-bit control word that picks a clock divider, an acquisition length, an input mode, a trigger source and three gating bits: start-enable, converter-enable and power. Two further registers name the positive and negative input channels. Once a trigger is accepted, the sequencer runs three phases. It holds the sample/hold strobe for the acquisition phase, then holds the convert strobe for a fixed conversion phase, then raises a one-cycle data-valid pulse that carries the 12-bit result taken from the converter.

Conversions can start from six sources: an external start pin, two timer pulses, a programmable-logic trigger, a one-shot software request and a free-running software mode. The sources last for different lengths of time. A one-shot request rewrites its own trigger code to the pin code when it finishes. Free-running mode keeps going after start-enable is cleared. No conversion starts until the converter has been powered for a set number of system clocks.

Timing, channel and mode settings are captured when a conversion launches. A write made during a conversion therefore applies from the next conversion on. Clearing the enable bit or the power bit cuts a conversion short.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x0600 (divider code 001, acquisition code 10, all other fields 0), the positive channel reads 0 and the negative channel reads 1. Busy and data-valid are low. Register reads return data one cycle after the address, on addresses 0 (control), 1 (positive channel) and 2 (negative channel), and bits 15:13 of the control word always read 0.
- R2: Divider code d (bits 12:10, 0..5) gives 2^d system clocks per divided clock. Acquisition code a (bits 9:8) gives 2·2^a divided clocks. Sample/hold stays high for (2<<a)<<d cycles, then convert stays high for 14<<d cycles, then data-valid is high for one cycle. Busy is high for all of these cycles.
- R3: While start-enable (bit 7) is 0, no trigger of any source launches a conversion.
- R4: A conversion launches no earlier than PWRUP_CYC+1 clock edges after the write that sets power (bit 5). With every other condition already met, it launches on exactly that edge. Clearing power resets the count.
- R5: Trigger code (bits 2:0) 000 selects the start pin, 001 selects timer 1, 010 selects timer 0 and 101 selects the logic trigger. Each of these launches on a synchronized rising edge, and busy is high after the third clock edge that follows the input's rise. Codes 110 and 111 start nothing.
- R6: Code 011 launches one conversion on the edge after the write. When it completes, the trigger field reads 000, and a later rising edge on the start pin then launches a conversion.
- R7: Code 100 converts repeatedly with one idle cycle between conversions. Clearing start-enable does not stop it. Changing the trigger code stops it after the current conversion.
- R8: Trigger edges that arrive while busy are neither acted on nor queued.
- R9: Clearing enable (bit 6) while busy drops busy after the next clock edge, and data-valid does not appear.
- R10: Channel, mode and timing values are captured at launch. The channel outputs and the phase lengths of a running conversion do not change when those registers are written during the conversion.
- R11: A write is ignored for a field given a reserved code: divider 110/111, mode 11, or a channel word above 19. The field keeps its old value.
- R12: When data-valid is high, the result equals the converter data present in the last convert cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 positive, 2 negative) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| start_pin | input | 1 | External start input |
| tmr1_pulse | input | 1 | Timer 1 trigger |
| tmr0_pulse | input | 1 | Timer 0 trigger |
| pla_trig | input | 1 | Programmable-logic trigger |
| cnv_data | input | 12 | Converter result |
| busy | output | 1 | Conversion in progress |
| smp_hold | output | 1 | Acquisition (sample/hold) strobe |
| conv_go | output | 1 | Conversion strobe |
| cnv_pos | output | 5 | Captured positive channel |
| cnv_neg | output | 5 | Captured negative channel |
| cnv_mode | output | 2 | Captured input mode |
| dout_valid | output | 1 | One-cycle result strobe |
| dout | output | 12 | Conversion result |

## Verification
A software launch makes busy visible one edge after the write. A pin, timer or logic trigger makes it visible three edges after the input rises, and a first launch after power-up waits PWRUP_CYC+1 edges. An abort shows one edge after the disabling write, and register reads arrive one edge after the address. The bench drives and samples on the falling edge and counts falling edges from the stimulus to the exact cycle each result is due. Phase lengths are counted in whole cycles and compared against bench functions of the divider and acquisition codes. Checks that expect nothing to happen watch the outputs over a window that is longer than any legal latency.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV, ST_DONE} seq_st_e;

  localparam logic [2:0] TRG_PIN   = 3'b000;
  localparam logic [2:0] TRG_TMR1  = 3'b001;
  localparam logic [2:0] TRG_TMR0  = 3'b010;
  localparam logic [2:0] TRG_SWONE = 3'b011;
  localparam logic [2:0] TRG_SWRUN = 3'b100;
  localparam logic [2:0] TRG_LOGIC = 3'b101;

  localparam int MAX_DIV_CODE = 5;

  // control word, bits 12:0 (15:13 not stored)
  typedef struct packed {
    logic [2:0] div;
    logic [1:0] acq;
    logic       go_en;
    logic       on;
    logic       pwr;
    logic [1:0] mode;
    logic [2:0] trig;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = ctrl_t'(13'h0600);
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int CH_W   = 5,
  parameter int CH_MAX = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             clr_trig,
  output ctrl_t            ctrl,
  output logic [CH_W-1:0]  pos_ch,
  output logic [CH_W-1:0]  neg_ch,
  output logic [REG_W-1:0] rd_data
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic ch_ok;
  assign ch_ok = (wr_data <= REG_W'(CH_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= CTRL_RST;
      pos_ch  <= '0;
      neg_ch  <= CH_W'(1);
      rd_data <= '0;
    end else begin
      if (clr_trig) ctrl.trig <= TRG_PIN;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            ctrl.trig  <= wr_data[2:0];
            ctrl.pwr   <= wr_data[5];
            ctrl.on    <= wr_data[6];
            ctrl.go_en <= wr_data[7];
            ctrl.acq   <= wr_data[9:8];
            if (wr_data[4:3] != 2'b11) ctrl.mode <= wr_data[4:3];
            if (int'(wr_data[12:10]) <= MAX_DIV_CODE) ctrl.div <= wr_data[12:10];
          end
          2'd1: if (ch_ok) pos_ch <= wr_data[CH_W-1:0];
          2'd2: if (ch_ok) neg_ch <= wr_data[CH_W-1:0];
          default: ;
        endcase
      end
      case (rd_addr)
        2'd0:    rd_data <= {{(REG_W-CTRL_W){1'b0}}, ctrl};
        2'd1:    rd_data <= {{(REG_W-CH_W){1'b0}}, pos_ch};
        2'd2:    rd_data <= {{(REG_W-CH_W){1'b0}}, neg_ch};
        default: rd_data <= '0;
      endcase
    end
  end

  a_r11_div_legal: assert property (@(posedge clk) disable iff (rst)
    int'(ctrl.div) <= MAX_DIV_CODE);
  a_r11_mode_legal: assert property (@(posedge clk) disable iff (rst)
    ctrl.mode != 2'b11);
  a_r11_ch_legal: assert property (@(posedge clk) disable iff (rst)
    (int'(pos_ch) <= CH_MAX) && (int'(neg_ch) <= CH_MAX));
  a_r6_autoclear: assert property (@(posedge clk) disable iff (rst)
    (clr_trig && !(wr_en && wr_addr == 2'd0)) |=> ctrl.trig == TRG_PIN);
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int N_SRC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] raw,
  output logic [N_SRC-1:0] rise
);
  logic [N_SRC-1:0] stage [SYNC_STAGES];
  logic [N_SRC-1:0] last;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else if (g == 0) stage[g] <= raw;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= '0;
    else     last <= stage[SYNC_STAGES-1];
  end

  assign rise = stage[SYNC_STAGES-1] & ~last;
endmodule

// File: rtl/adc_seq_pwr.sv
module adc_seq_pwr #(
  parameter int PWRUP_CYC = 210
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_on,
  output logic ready
);
  localparam int CW = $clog2(PWRUP_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_on)             cnt <= '0;
    else if (cnt != CW'(PWRUP_CYC)) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == CW'(PWRUP_CYC));

  a_r4_ready_needs_power: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> !ready);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CH_W      = 5,
  parameter int CONV_CLKS = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [CH_W-1:0]   pos_ch,
  input  logic [CH_W-1:0]   neg_ch,
  input  logic              pwr_ready,
  input  logic [3:0]        rise,
  input  logic [DATA_W-1:0] cnv_data,
  output logic              busy,
  output logic              smp_hold,
  output logic              conv_go,
  output logic              dout_valid,
  output logic [DATA_W-1:0] dout,
  output logic [CH_W-1:0]   cnv_pos,
  output logic [CH_W-1:0]   cnv_neg,
  output logic [1:0]        cnv_mode,
  output logic              clr_trig
);
  localparam int LONGEST = ((CONV_CLKS > 16) ? CONV_CLKS : 16) << MAX_DIV_CODE;
  localparam int CNT_W   = $clog2(LONGEST);
  localparam int LW      = CNT_W + 1;

  seq_st_e          st;
  logic [CNT_W-1:0] cnt, acq_last, conv_last;
  logic             cont_run, act_single;
  logic             abort, edge_hit, sw_req, launch;
  logic [LW-1:0]    acq_len, conv_len;

  assign abort  = !ctrl.on || !ctrl.pwr;
  assign sw_req = (ctrl.trig == TRG_SWONE) || (ctrl.trig == TRG_SWRUN);

  always_comb begin
    case (ctrl.trig)
      TRG_PIN:   edge_hit = rise[0];
      TRG_TMR1:  edge_hit = rise[1];
      TRG_TMR0:  edge_hit = rise[2];
      TRG_LOGIC: edge_hit = rise[3];
      default:   edge_hit = 1'b0;
    endcase
  end

  assign launch = (st == ST_IDLE) && !abort && pwr_ready &&
                  ((ctrl.go_en && (edge_hit || sw_req)) ||
                   (cont_run && ctrl.trig == TRG_SWRUN));

  assign acq_len  = (LW'(2) << ctrl.acq) << ctrl.div;
  assign conv_len = LW'(CONV_CLKS) << ctrl.div;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      acq_last   <= '0;
      conv_last  <= '0;
      cont_run   <= 1'b0;
      act_single <= 1'b0;
      dout       <= '0;
      cnv_pos    <= '0;
      cnv_neg    <= CH_W'(1);
      cnv_mode   <= '0;
    end else if (abort) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cont_run <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (launch) begin
            st         <= ST_ACQ;
            cnt        <= '0;
            acq_last   <= CNT_W'(acq_len - 1'b1);
            conv_last  <= CNT_W'(conv_len - 1'b1);
            cnv_pos    <= pos_ch;
            cnv_neg    <= neg_ch;
            cnv_mode   <= ctrl.mode;
            act_single <= (ctrl.trig == TRG_SWONE);
            cont_run   <= (ctrl.trig == TRG_SWRUN);
          end else if (ctrl.trig != TRG_SWRUN) begin
            cont_run <= 1'b0;
          end
        end
        ST_ACQ: begin
          if (cnt == acq_last) begin
            st  <= ST_CONV;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_CONV: begin
          if (cnt == conv_last) begin
            st   <= ST_DONE;
            cnt  <= '0;
            dout <= cnv_data;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign smp_hold   = (st == ST_ACQ);
  assign conv_go    = (st == ST_CONV);
  assign dout_valid = (st == ST_DONE);
  assign clr_trig   = (st == ST_DONE) && act_single;

  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> !dout_valid);
  a_r2_acq_before_conv: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_go) |-> $past(smp_hold));
  a_r4_launch_powered: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(pwr_ready));
  a_r3_go_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(ctrl.go_en) || $past(cont_run)));
  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    !ctrl.on |=> !busy);
  a_r10_hold_channel: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cnv_pos));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int DATA_W      = 12,
  parameter int CH_W        = 5,
  parameter int CH_MAX      = 19,
  parameter int CONV_CLKS   = 14,
  parameter int PWRUP_CYC   = 210,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              start_pin,
  input  logic              tmr1_pulse,
  input  logic              tmr0_pulse,
  input  logic              pla_trig,
  input  logic [DATA_W-1:0] cnv_data,
  output logic              busy,
  output logic              smp_hold,
  output logic              conv_go,
  output logic [CH_W-1:0]   cnv_pos,
  output logic [CH_W-1:0]   cnv_neg,
  output logic [1:0]        cnv_mode,
  output logic              dout_valid,
  output logic [DATA_W-1:0] dout
);
  ctrl_t           ctrl;
  logic [CH_W-1:0] pos_ch, neg_ch;
  logic            clr_trig, pwr_ready;
  logic [3:0]      rise;

  adc_seq_regs #(.REG_W(REG_W), .CH_W(CH_W), .CH_MAX(CH_MAX)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .clr_trig(clr_trig), .ctrl(ctrl), .pos_ch(pos_ch),
    .neg_ch(neg_ch), .rd_data(rd_data));

  adc_seq_trig #(.N_SRC(4), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst(rst), .raw({pla_trig, tmr0_pulse, tmr1_pulse, start_pin}),
    .rise(rise));

  adc_seq_pwr #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
    .clk(clk), .rst(rst), .pwr_on(ctrl.pwr), .ready(pwr_ready));

  adc_seq_fsm #(.DATA_W(DATA_W), .CH_W(CH_W), .CONV_CLKS(CONV_CLKS)) u_fsm (
    .clk(clk), .rst(rst), .ctrl(ctrl), .pos_ch(pos_ch), .neg_ch(neg_ch),
    .pwr_ready(pwr_ready), .rise(rise), .cnv_data(cnv_data), .busy(busy),
    .smp_hold(smp_hold), .conv_go(conv_go), .dout_valid(dout_valid),
    .dout(dout), .cnv_pos(cnv_pos), .cnv_neg(cnv_neg), .cnv_mode(cnv_mode),
    .clr_trig(clr_trig));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PWR = 210;

  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic start_pin = 0, tmr1_pulse = 0, tmr0_pulse = 0, pla_trig = 0;
  logic [11:0] cnv_data = 0, dout;
  logic busy, smp_hold, conv_go, dout_valid;
  logic [4:0] cnv_pos, cnv_neg;
  logic [1:0] cnv_mode;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.PWRUP_CYC(PWR)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start_pin(start_pin),
    .tmr1_pulse(tmr1_pulse), .tmr0_pulse(tmr0_pulse), .pla_trig(pla_trig),
    .cnv_data(cnv_data), .busy(busy), .smp_hold(smp_hold), .conv_go(conv_go),
    .cnv_pos(cnv_pos), .cnv_neg(cnv_neg), .cnv_mode(cnv_mode),
    .dout_valid(dout_valid), .dout(dout));

  function automatic logic [15:0] mk(int d, int a, bit go, bit on, bit pw, int m, int t);
    return {3'b000, 3'(d), 2'(a), go, on, pw, 2'(m), 3'(t)};
  endfunction
  function automatic int exp_acq(int d, int a); return (2 << a) << d; endfunction
  function automatic int exp_conv(int d); return 14 << d; endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = int'(rd_data);
  endtask

  task automatic wait_busy(input int maxc, output int j);
    j = 0;
    while (!busy && j < maxc) begin @(negedge clk); j++; end
  endtask

  // counts from the current negedge while busy is high
  task automatic measure(output int na, output int nc, output int nb, output int nv, output int dv);
    na = 0; nc = 0; nb = 0; nv = 0; dv = -1;
    while (busy && nb < 3000) begin
      nb++;
      if (smp_hold) na++;
      if (conv_go) nc++;
      if (dout_valid) begin nv++; dv = int'(dout); end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (busy) seen++; end
  endtask

  task automatic set_src(input int idx, input logic v);
    case (idx)
      0: start_pin = v;
      1: tmr1_pulse = v;
      2: tmr0_pulse = v;
      default: pla_trig = v;
    endcase
  endtask

  task automatic fire(input int idx, input int maxc, output int j);
    @(negedge clk); set_src(idx, 1'b1);
    j = 0;
    while (!busy && j < maxc) begin @(negedge clk); j++; end
    set_src(idx, 1'b0);
  endtask

  task automatic run_single(input int d, input int a, input string req);
    int j, na, nc, nb, nv, dv, v;
    cnv_data = 12'($urandom);
    wr(0, mk(d, a, 1, 1, 1, 0, 3));
    wait_busy(5, j);
    chk({req, " R6 launch latency"}, j, 1);
    v = int'(cnv_data);
    measure(na, nc, nb, nv, dv);
    chk({req, " R2 acquisition"}, na, exp_acq(d, a));
    chk({req, " R2 conversion"}, nc, exp_conv(d));
    chk({req, " R2 busy length"}, nb, exp_acq(d, a) + exp_conv(d) + 1);
    chk({req, " R12 data"}, dv, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v, j, na, nc, nb, nv, dv, seen, rises, gap, maxgap;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 valid", int'(dout_valid), 0);
    rd(0, v); chk("R1 ctrl", v, 16'h0600);
    rd(1, v); chk("R1 pos", v, 0);
    rd(2, v); chk("R1 neg", v, 1);

    // R4 power-up delay
    cnv_data = 12'h5A3;
    wr(0, mk(0, 0, 1, 1, 1, 0, 3));
    wait_busy(PWR + 20, j);
    chk("R4 first launch edge", j, PWR + 1);
    measure(na, nc, nb, nv, dv);
    chk("R2 busy length d0 a0", nb, 17);
    chk("R12 data", dv, 12'h5A3);
    chk("R2 valid count", nv, 1);
    rd(0, v); chk("R6 trigger auto-cleared", v & 7, 0);

    // R2 divider sweep with random acquisition
    for (int d = 0; d <= 5; d++) run_single(d, int'($urandom % 4), "sweep");

    // R5 start pin after auto-clear (ctrl now trig 000, go set)
    wr(0, mk(0, 0, 1, 1, 1, 0, 0));
    fire(0, 10, j); chk("R5 R6 pin launch latency", j, 3);
    // R8 retrigger while busy
    repeat (2) @(negedge clk); start_pin = 1;
    repeat (2) @(negedge clk); start_pin = 0;
    measure(na, nc, nb, nv, dv);
    quiet(12, seen); chk("R8 edge during busy ignored", seen, 0);

    // R5 timers and logic trigger
    wr(0, mk(0, 0, 1, 1, 1, 0, 1));
    fire(1, 10, j); chk("R5 timer1 latency", j, 3);
    measure(na, nc, nb, nv, dv);
    wr(0, mk(0, 0, 1, 1, 1, 0, 2));
    fire(2, 10, j); chk("R5 timer0 latency", j, 3);
    measure(na, nc, nb, nv, dv);
    wr(0, mk(0, 0, 1, 1, 1, 0, 5));
    fire(3, 10, j); chk("R5 logic trigger latency", j, 3);
    measure(na, nc, nb, nv, dv);
    // wrong source for selected code
    fire(0, 10, j); chk("R5 unselected source", int'(busy), 0);
    // R5 reserved codes
    wr(0, mk(0, 0, 1, 1, 1, 0, 6));
    for (int s = 0; s < 4; s++) begin fire(s, 8, j); chk("R5 reserved 110", int'(busy), 0); end
    wr(0, mk(0, 0, 1, 1, 1, 0, 7));
    quiet(10, seen); chk("R5 reserved 111", seen, 0);

    // R3 start-enable cleared
    wr(0, mk(0, 0, 0, 1, 1, 0, 0));
    fire(0, 10, j); chk("R3 pin blocked", int'(busy), 0);
    wr(0, mk(0, 0, 0, 1, 1, 0, 3));
    quiet(10, seen); chk("R3 software blocked", seen, 0);

    // R7 continuous
    wr(0, mk(0, 0, 1, 1, 1, 0, 4));
    wait_busy(5, j); chk("R7 continuous launch", j, 1);
    wr(0, mk(0, 0, 0, 1, 1, 0, 4));
    rises = 0; gap = 0; maxgap = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (busy) begin if (gap > 0) rises++; if (gap > maxgap) maxgap = gap; gap = 0; end
      else gap++;
    end
    chk("R7 keeps running with go cleared", int'(rises >= 5), 1);
    chk("R7 one idle cycle between", maxgap, 1);
    wr(0, mk(0, 0, 0, 1, 1, 0, 0));
    j = 0; while (busy && j < 40) begin @(negedge clk); j++; end
    quiet(40, seen); chk("R7 stops on code change", seen, 0);

    // R9 abort by enable clear
    wr(0, mk(5, 3, 1, 1, 1, 0, 3));
    wait_busy(5, j);
    repeat (10) @(negedge clk);
    wr(0, mk(5, 3, 1, 0, 1, 0, 3));
    nv = int'(dout_valid);
    @(negedge clk);
    chk("R9 busy dropped", int'(busy), 0);
    quiet(5, seen); chk("R9 no valid/relaunch", seen + nv + int'(dout_valid), 0);
    wr(0, mk(0, 0, 0, 1, 1, 0, 0));

    // R10 capture at launch
    wr(1, 16'd7); wr(2, 16'd3);
    wr(0, mk(1, 1, 1, 1, 1, 2, 3));
    wait_busy(5, j);
    wr(1, 16'd12);
    wr(0, mk(0, 0, 0, 1, 1, 1, 0));
    chk("R10 pos held", int'(cnv_pos), 7);
    chk("R10 neg held", int'(cnv_neg), 3);
    chk("R10 mode held", int'(cnv_mode), 2);
    measure(na, nc, nb, nv, dv);
    chk("R10 timing held", nb + 4, exp_acq(1, 1) + exp_conv(1) + 1);
    wr(0, mk(0, 0, 1, 1, 1, 1, 3));
    wait_busy(5, j);
    chk("R10 new pos applied", int'(cnv_pos), 12);
    chk("R10 new mode applied", int'(cnv_mode), 1);
    measure(na, nc, nb, nv, dv);

    // R11 reserved writes
    wr(1, 16'd25); rd(1, v); chk("R11 pos 25 ignored", v, 12);
    wr(2, 16'h0103); rd(2, v); chk("R11 neg wide word ignored", v, 3);
    wr(2, 16'd19); rd(2, v); chk("R11 neg 19 accepted", v, 19);
    wr(0, 16'hE000 | mk(6, 2, 0, 1, 1, 3, 0));
    rd(0, v); chk("R11 R1 div/mode kept", v, int'(mk(0, 2, 0, 1, 1, 1, 0)));

    // R4 power cycle restarts delay
    wr(0, mk(0, 0, 0, 1, 0, 0, 0));
    wr(0, mk(0, 0, 1, 1, 1, 0, 3));
    wait_busy(PWR + 20, j);
    chk("R4 delay after power cycle", j, PWR + 1);
    measure(na, nc, nb, nv, dv);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule